// File: doc/BRIEF.md
# Privileged CSR Read-Write Unit

This block holds the control and status registers of a small 32-bit core and carries out the atomic read-write CSR instruction. Each request names a 12-bit register address and gives the current privilege mode. It also gives two flags that say whether the destination register and the source register are the zero register, plus the source operand. The block returns the old register value for writeback and stores the operand. It flags an illegal-instruction trap when the access is not allowed.

The read half and the write half of a request are independent. A zero destination skips the read and its permission check. A zero source skips the write and its permission check. The minimum privilege comes from address bits [9:8]. Addresses whose bits [11:10] are 2'b11 form a read-only bank. Every completed write also produces a one-cycle event that carries the address, the old value and the new value, so that neighbouring logic can follow CSR changes.

The implemented registers are four read-write words and one read-only word:
- 0x300: machine status.
- 0x340: machine scratch.
- 0x140: supervisor scratch.
- 0x800: user scratch.
- 0xF14: read-only hart number, a parameter constant.

Top module: `csr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every read-write CSR is cleared to zero, and all response and event outputs are low in the following cycle.
- R2: A request is a one-cycle pulse on `req_valid`. Its results (`rsp_trap`, `rsp_rd_valid`, `rsp_rd_data`, the `wev_*` outputs) appear in the cycle after the one in which it is sampled. In a cycle that follows no request, `rsp_trap`, `rsp_rd_valid` and `wev_valid` are low.
- R3: Privilege modes are encoded as user = 0, supervisor = 1 and machine = 3 on the 2-bit `req_mode`. An active access to an address whose bits [9:8] exceed `req_mode` raises `rsp_trap`.
- R4: A write to an address whose bits [11:10] are 2'b11 raises `rsp_trap` even in machine mode, and leaves the register unchanged. Reading such an address with sufficient privilege is allowed; 0xF14 returns `HART_ID`.
- R5: When `req_rd_zero` is 1, no read is performed and no read permission check is made. `rsp_rd_valid` stays low, and a request with both flags set never traps.
- R6: When `req_rs_zero` is 1, the addressed CSR keeps its value, no write permission check is made and no write event is produced.
- R7: When both halves are active, `rsp_rd_data` is the value the CSR held before the request, and the CSR then holds `req_wdata`.
- R8: Every completed write asserts `wev_valid` for one cycle, with `wev_addr` the address, `wev_old` the previous contents and `wev_new` the stored value.
- R9: An active access to an address outside the implemented set raises `rsp_trap` and changes no CSR.
- R10: In a cycle where `rsp_trap` is high, `rsp_rd_valid` and `wev_valid` are low, and the trapped request changes no CSR.
- R11: `status_uie` always equals bit 0 of the machine status CSR at 0x300.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_addr | input | 12 | CSR address |
| req_mode | input | 2 | Current privilege mode (0 user, 1 supervisor, 3 machine) |
| req_rd_zero | input | 1 | Destination register is the zero register |
| req_rs_zero | input | 1 | Source register is the zero register |
| req_wdata | input | XLEN | Source operand to be stored |
| rsp_trap | output | 1 | Illegal-instruction trap for the previous request |
| rsp_rd_valid | output | 1 | Writeback value is valid |
| rsp_rd_data | output | XLEN | Old CSR value for writeback |
| wev_valid | output | 1 | One-cycle write event |
| wev_addr | output | 12 | Address written |
| wev_old | output | XLEN | Contents before the write |
| wev_new | output | XLEN | Contents after the write |
| status_uie | output | 1 | User interrupt enable, bit 0 of machine status |

## Verification
The bench builds the block with `XLEN` = 32 and `HART_ID` = 5. A nonzero hart number lets a read of the read-only bank be told apart from a reset value or a suppressed read. A machine-mode write of that address shows that the read-only rule fires on its own, without a privilege failure. All three privilege levels are driven against addresses in the user, supervisor and machine ranges. Back-to-back requests and idle gaps are mixed, so that per-request latency and the ordering of the old value against the stored value are both observed.

// File: rtl/csr_unit_pkg.sv
// Shared definitions for the CSR unit: privilege encoding, the implemented
// address set and the bit fields decoded from an address.
// Assumes: a 12-bit CSR address space; index 0 of the read-write set is status.
package csr_unit_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_t;

    localparam int ADDR_W = 12;
    localparam int NUM_RW = 4;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 12'h300;
    localparam logic [ADDR_W-1:0] ADDR_MSCR   = 12'h340;
    localparam logic [ADDR_W-1:0] ADDR_SSCR   = 12'h140;
    localparam logic [ADDR_W-1:0] ADDR_USCR   = 12'h800;
    localparam logic [ADDR_W-1:0] ADDR_HART   = 12'hF14;

    localparam logic [1:0] RO_BANK        = 2'b11;
    localparam int         STATUS_UIE_BIT = 0;

    // Address of read-write entry idx; entry 0 must stay the status word.
    function automatic logic [ADDR_W-1:0] rw_addr(input int idx);
        case (idx)
            0:       rw_addr = ADDR_STATUS;
            1:       rw_addr = ADDR_MSCR;
            2:       rw_addr = ADDR_SSCR;
            3:       rw_addr = ADDR_USCR;
            default: rw_addr = '0;
        endcase
    endfunction

endpackage

// File: rtl/csr_decode.sv
// Address decoder: one-hot hit vector over the read-write entries, a hit
// flag for the read-only constant, and an "implemented" summary.
// Assumes: the addresses returned by rw_addr are distinct.
module csr_decode
    import csr_unit_pkg::*;
#(
    parameter int N_RW = NUM_RW
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_RW-1:0]   rw_hit,
    output logic              ro_hit,
    output logic              known
);

    // One comparator per implemented read-write entry.
    for (genvar g = 0; g < N_RW; g++) begin : g_cmp
        assign rw_hit[g] = (addr == rw_addr(g));
    end

    // Read-only constant and overall hit.
    always_comb begin
        ro_hit = (addr == ADDR_HART);
        known  = (|rw_hit) | ro_hit;
    end

endmodule

// File: rtl/csr_perm.sv
// Permission check taken from the address alone: the privilege level in
// bits [9:8] and the read-only bank in bits [11:10]. A half that is not
// active is not checked.
// Assumes: want_rd and want_wr are already qualified by the request strobe.
module csr_perm
    import csr_unit_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  priv_t             mode,
    input  logic              want_rd,
    input  logic              want_wr,
    input  logic              known,
    output logic              deny
);

    logic level_short;
    logic in_ro_bank;

    // Combine level, bank and presence into one trap decision.
    always_comb begin
        level_short = addr[9:8] > mode;
        in_ro_bank  = addr[11:10] == RO_BANK;
        deny        = ((want_rd | want_wr) & (~known | level_short))
                    | (want_wr & in_ro_bank);
    end

endmodule

// File: rtl/csr_store.sv
// Storage for the read-write CSRs; each entry loads when its select bit is set.
// Assumes: at most one select bit is high per cycle.
module csr_store #(
    parameter int XLEN = 32,
    parameter int N_RW = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_RW-1:0]           wr_sel,
    input  logic [XLEN-1:0]           wr_data,
    output logic [N_RW-1:0][XLEN-1:0] q
);

    for (genvar g = 0; g < N_RW; g++) begin : g_reg
        // Entry g: clear on reset, load on select.
        always_ff @(posedge clk) begin
            if (!rst_n)         q[g] <= '0;
            else if (wr_sel[g]) q[g] <= wr_data;
        end
    end

endmodule

// File: rtl/csr_unit.sv
// CSR read-write unit: performs the conditional read and write halves of a
// request, traps disallowed accesses and reports every write as an event.
// Assumes: req_valid is a single-cycle strobe; outputs follow one cycle later.
module csr_unit
    import csr_unit_pkg::*;
#(
    parameter int              XLEN    = 32,
    parameter logic [XLEN-1:0] HART_ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [11:0]       req_addr,
    input  logic [1:0]        req_mode,
    input  logic              req_rd_zero,
    input  logic              req_rs_zero,
    input  logic [XLEN-1:0]   req_wdata,
    output logic              rsp_trap,
    output logic              rsp_rd_valid,
    output logic [XLEN-1:0]   rsp_rd_data,
    output logic              wev_valid,
    output logic [11:0]       wev_addr,
    output logic [XLEN-1:0]   wev_old,
    output logic [XLEN-1:0]   wev_new,
    output logic              status_uie
);

    localparam int N_RW = NUM_RW;

    logic                      want_rd, want_wr;
    logic [N_RW-1:0]           rw_hit, wr_sel;
    logic                      ro_hit, known, deny;
    logic [N_RW-1:0][XLEN-1:0] cur;
    logic [XLEN-1:0]           old_val;
    logic                      do_rd, do_wr;

    // Qualify each half by the strobe and its zero-register flag.
    always_comb begin
        want_rd = req_valid & ~req_rd_zero;
        want_wr = req_valid & ~req_rs_zero;
    end

    csr_decode #(.N_RW(N_RW)) u_dec (
        .addr   (req_addr),
        .rw_hit (rw_hit),
        .ro_hit (ro_hit),
        .known  (known)
    );

    csr_perm u_perm (
        .addr    (req_addr),
        .mode    (priv_t'(req_mode)),
        .want_rd (want_rd),
        .want_wr (want_wr),
        .known   (known),
        .deny    (deny)
    );

    // Select the current contents of the addressed CSR (one-hot OR mux).
    always_comb begin
        old_val = ro_hit ? HART_ID : '0;
        for (int i = 0; i < N_RW; i++) begin
            if (rw_hit[i]) old_val = old_val | cur[i];
        end
    end

    // Only an allowed access performs its halves.
    always_comb begin
        do_rd  = want_rd & ~deny;
        do_wr  = want_wr & ~deny;
        wr_sel = do_wr ? rw_hit : '0;
    end

    csr_store #(.XLEN(XLEN), .N_RW(N_RW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wr_data (req_wdata),
        .q       (cur)
    );

    // Register the response and the write event one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_trap     <= 1'b0;
            rsp_rd_valid <= 1'b0;
            rsp_rd_data  <= '0;
            wev_valid    <= 1'b0;
            wev_addr     <= '0;
            wev_old      <= '0;
            wev_new      <= '0;
        end else begin
            rsp_trap     <= deny;
            rsp_rd_valid <= do_rd;
            rsp_rd_data  <= do_rd ? old_val : '0;
            wev_valid    <= do_wr;
            wev_addr     <= do_wr ? req_addr : '0;
            wev_old      <= do_wr ? old_val : '0;
            wev_new      <= do_wr ? req_wdata : '0;
        end
    end

    // Status bit brought out for interrupt logic.
    assign status_uie = cur[0][STATUS_UIE_BIT];

endmodule

// File: rtl/csr_unit_chk.sv
// Checker for csr_unit, bound to every instance. Relates the registered
// outputs to the request of the previous cycle.
// Assumes: port names match those of csr_unit.
module csr_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [11:0]     req_addr,
    input logic [1:0]      req_mode,
    input logic            req_rd_zero,
    input logic            req_rs_zero,
    input logic [XLEN-1:0] req_wdata,
    input logic            rsp_trap,
    input logic            rsp_rd_valid,
    input logic [XLEN-1:0] rsp_rd_data,
    input logic            wev_valid,
    input logic [11:0]     wev_addr,
    input logic [XLEN-1:0] wev_old,
    input logic [XLEN-1:0] wev_new,
    input logic            status_uie
);

    logic armed;

    // Marks that the previous edge was out of reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r10_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (!rsp_rd_valid && !wev_valid));

    a_r4_ro_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        wev_valid |-> (wev_addr[11:10] != 2'b11));

    a_r3_priv_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(req_valid) && $past(!(req_rd_zero && req_rs_zero))
         && $past(req_addr[9:8] > req_mode)) |-> rsp_trap);

    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(req_valid)) |-> (!rsp_trap && !rsp_rd_valid && !wev_valid));

    a_r5_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(req_valid && req_rd_zero)) |-> !rsp_rd_valid);

    a_r6_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(req_valid && req_rs_zero)) |-> !wev_valid);

    a_r8_event_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wev_valid) |-> (wev_new == $past(req_wdata) && wev_addr == $past(req_addr)));

    a_r7_old_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rd_valid && wev_valid) |-> (rsp_rd_data == wev_old));

    a_r11_uie_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wev_valid && wev_addr == 12'h300) |-> (status_uie == wev_new[0]));

endmodule

bind csr_unit csr_unit_chk #(.XLEN(XLEN)) u_csr_unit_chk (.*);

// File: tb/test_csr_unit.sv
// Scoreboard bench for csr_unit: the driver computes each expected response
// from a register model and queues it; the monitor compares one cycle later.
`timescale 1ns/1ps
module test_csr_unit;

    localparam int              XLEN = 32;
    localparam logic [XLEN-1:0] HART = 32'h5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [1:0]      req_mode = '0;
    logic            req_rd_zero = 1'b1;
    logic            req_rs_zero = 1'b1;
    logic [XLEN-1:0] req_wdata = '0;
    logic            rsp_trap, rsp_rd_valid, wev_valid, status_uie;
    logic [XLEN-1:0] rsp_rd_data, wev_old, wev_new;
    logic [11:0]     wev_addr;

    always #2 clk = ~clk;

    csr_unit #(.XLEN(XLEN), .HART_ID(HART)) i_csr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_mode(req_mode), .req_rd_zero(req_rd_zero), .req_rs_zero(req_rs_zero),
        .req_wdata(req_wdata), .rsp_trap(rsp_trap), .rsp_rd_valid(rsp_rd_valid),
        .rsp_rd_data(rsp_rd_data), .wev_valid(wev_valid), .wev_addr(wev_addr),
        .wev_old(wev_old), .wev_new(wev_new), .status_uie(status_uie)
    );

    typedef struct {
        logic            trap;
        logic            rdv;
        logic [XLEN-1:0] rdd;
        logic            ev;
        logic [11:0]     ea;
        logic [XLEN-1:0] eo;
        logic [XLEN-1:0] en;
        logic            uie;
        string           tag;
    } exp_t;

    exp_t            sb[$];
    logic [XLEN-1:0] mdl[4];
    int              total = 0;
    int              fails = 0;
    logic            seen = 1'b0;
    logic            started = 1'b0;
    logic            done = 1'b0;

    function automatic int idx_of(input logic [11:0] a);
        case (a)
            12'h300: return 0;
            12'h340: return 1;
            12'h140: return 2;
            12'h800: return 3;
            default: return -1;
        endcase
    endfunction

    // Driver: compute the expected result from the requirements, then drive.
    task automatic issue(input logic [11:0] a, input logic [1:0] m, input logic rdz,
                         input logic rsz, input logic [XLEN-1:0] d, input string tag);
        exp_t e;
        int   k;
        logic rd_on, wr_on, impl;
        logic [XLEN-1:0] oldv;
        @(negedge clk);
        k     = idx_of(a);
        rd_on = !rdz;
        wr_on = !rsz;
        impl  = (k >= 0) || (a == 12'hF14);
        oldv  = (k >= 0) ? mdl[k] : ((a == 12'hF14) ? HART : '0);
        e.trap = ((rd_on || wr_on) && (!impl || (a[9:8] > m))) || (wr_on && a[11:10] == 2'b11);
        e.rdv  = rd_on && !e.trap;
        e.rdd  = oldv;
        e.ev   = wr_on && !e.trap;
        e.ea   = a;
        e.eo   = oldv;
        e.en   = d;
        if (e.ev && k >= 0) mdl[k] = d;
        e.uie  = mdl[0][0];
        e.tag  = tag;
        sb.push_back(e);
        req_valid   = 1'b1;
        req_addr    = a;
        req_mode    = m;
        req_rd_zero = rdz;
        req_rs_zero = rsz;
        req_wdata   = d;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Remembers whether the design sampled a request at this edge.
    always @(posedge clk) seen <= rst_n && req_valid;

    // Monitor: pop and compare after each request, otherwise expect idle (R2).
    always @(negedge clk) begin
        if (started && !done) begin
            if (seen) begin
                exp_t e;
                logic bad;
                e = sb.pop_front();
                bad = (rsp_trap !== e.trap) || (rsp_rd_valid !== e.rdv)
                   || (wev_valid !== e.ev) || (status_uie !== e.uie)
                   || (e.rdv && rsp_rd_data !== e.rdd)
                   || (e.ev && (wev_addr !== e.ea || wev_old !== e.eo || wev_new !== e.en));
                total++;
                if (bad) begin
                    fails++;
                    $display("FAIL %s: actual trap=%0b rdv=%0b rdd=%h ev=%0b ea=%h eo=%h en=%h uie=%0b expected trap=%0b rdv=%0b rdd=%h ev=%0b ea=%h eo=%h en=%h uie=%0b",
                             e.tag, rsp_trap, rsp_rd_valid, rsp_rd_data, wev_valid, wev_addr,
                             wev_old, wev_new, status_uie, e.trap, e.rdv, e.rdd, e.ev, e.ea,
                             e.eo, e.en, e.uie);
                end
            end else begin
                total++;
                if (rsp_trap !== 1'b0 || rsp_rd_valid !== 1'b0 || wev_valid !== 1'b0) begin
                    fails++;
                    $display("FAIL R2 idle: actual trap=%0b rdv=%0b ev=%0b expected 0 0 0",
                             rsp_trap, rsp_rd_valid, wev_valid);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;
        gap(1);
        // R1: reset values, read in machine mode without writing; R4 hart read
        issue(12'h300, 2'd3, 1'b0, 1'b1, '0, "R1 status reset");
        issue(12'h340, 2'd3, 1'b0, 1'b1, '0, "R1 mscratch reset");
        issue(12'h140, 2'd3, 1'b0, 1'b1, '0, "R1 sscratch reset");
        issue(12'h800, 2'd3, 1'b0, 1'b1, '0, "R1 uscratch reset");
        issue(12'hF14, 2'd3, 1'b0, 1'b1, '0, "R4 hart read");
        gap(2);
        // R8 R11: write status with uie set, no read (R5)
        issue(12'h300, 2'd3, 1'b1, 1'b0, 32'h0000_0009, "R8 R11 status write");
        issue(12'h340, 2'd3, 1'b1, 1'b0, 32'hCAFE_0001, "R8 mscratch write");
        // R7: swap returns old value, stores new
        issue(12'h340, 2'd3, 1'b0, 1'b0, 32'h1234_5678, "R7 swap");
        issue(12'h340, 2'd3, 1'b0, 1'b1, '0, "R7 readback");
        gap(1);
        // R3: privilege from address bits [9:8]
        issue(12'h300, 2'd0, 1'b0, 1'b1, '0, "R3 user reads machine");
        issue(12'h340, 2'd1, 1'b0, 1'b0, 32'hDEAD, "R3 R10 super writes machine");
        issue(12'h340, 2'd3, 1'b0, 1'b1, '0, "R10 unchanged after trap");
        issue(12'h140, 2'd1, 1'b0, 1'b0, 32'h0000_0140, "R3 super swaps super");
        issue(12'h140, 2'd0, 1'b1, 1'b0, 32'h1, "R3 user writes super");
        issue(12'h800, 2'd0, 1'b0, 1'b0, 32'h0000_0800, "R3 user swaps user");
        gap(3);
        // R5: both halves off never traps, even without privilege
        issue(12'h300, 2'd0, 1'b1, 1'b1, 32'hFFFF, "R5 nothing at machine from user");
        issue(12'h305, 2'd0, 1'b1, 1'b1, 32'hFFFF, "R5 nothing at unknown");
        // R6: read-only bank read with no write is not write-checked
        issue(12'hF14, 2'd3, 1'b0, 1'b1, 32'h77, "R6 ro read without write");
        issue(12'h800, 2'd0, 1'b0, 1'b1, 32'h99, "R6 user read keeps value");
        issue(12'h800, 2'd0, 1'b0, 1'b1, '0, "R6 value kept");
        // R4: write to read-only bank traps in machine mode
        issue(12'hF14, 2'd3, 1'b1, 1'b0, 32'h42, "R4 ro write traps");
        issue(12'hF14, 2'd3, 1'b0, 1'b0, 32'h43, "R4 ro swap traps");
        issue(12'hF14, 2'd3, 1'b0, 1'b1, '0, "R4 ro value kept");
        gap(1);
        // R9: unimplemented addresses trap and change nothing
        issue(12'h305, 2'd3, 1'b0, 1'b0, 32'h55, "R9 unknown swap");
        issue(12'h7C0, 2'd3, 1'b1, 1'b0, 32'h66, "R9 unknown write");
        issue(12'h340, 2'd3, 1'b0, 1'b1, '0, "R9 mscratch kept");
        issue(12'h300, 2'd3, 1'b0, 1'b1, '0, "R9 status kept");
        // R11: clearing bit 0 drops uie; back-to-back writes (R2)
        issue(12'h300, 2'd3, 1'b0, 1'b0, 32'h0000_0008, "R11 uie clear");
        issue(12'h300, 2'd3, 1'b0, 1'b0, 32'h0000_0001, "R11 uie set");
        issue(12'h800, 2'd3, 1'b0, 1'b0, 32'hA5A5_A5A5, "R8 machine writes user");
        gap(4);
        done = 1'b1;
        if (sb.size() != 0) begin
            total++;
            fails++;
            $display("FAIL R2 leftover: actual %0d pending expected 0", sb.size());
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule